// File: doc/BRIEF.md
# Wraparound Post-Mask Generator

This block turns a 7-bit count code into a 64-bit mask and keeps the result in an output register. One code value sets two things at once: how long the run of zeros is, and which end of the word the run starts from. Codes in the lower half of the range (0 to 63) clear that many bits, starting at the most significant bit. Codes in the upper half (64 to 127) wrap around: they clear 128 minus the code bits, starting at the least significant bit. Every bit that is not cleared is one.

The code comes from one of two sources. An immediate operand supplies it when the immediate load strobe is high. The low bits of a 16-bit control word supply it when the control load strobe is high. The register changes only on a clock edge where a strobe is high. Between loads it holds its value, so the consumer can apply the mask to a datapath word.

Top module: `postMaskGen`

## Requirements
- R1: After reset, and until the first load, `maskOut` is all ones (64'hFFFF_FFFF_FFFF_FFFF).
- R2: Loading code 0 makes `maskOut` all ones.
- R3: Loading a code n from 1 to 63 makes `maskOut` bits [63:64-n] zero and bits [63-n:0] one.
- R4: Loading a code n from 64 to 127 makes `maskOut` bits [127-n:0] zero and all higher bits one. Code 64 therefore gives all zeros, and code 127 clears bit 0 only.
- R5: When `loadImm` is high at a rising clock edge, the code is `immCode[6:0]`. The new mask is visible after that edge.
- R6: When only `loadCtrl` is high at a rising clock edge, the code is `ctrlWord[6:0]`. Bits `ctrlWord[15:7]` have no effect on the mask.
- R7: When `loadImm` and `loadCtrl` are high at the same edge, the immediate code is used.
- R8: At an edge where neither strobe is high, `maskOut` keeps its value, whatever `immCode` and `ctrlWord` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadImm | input | 1 | Load the mask from the immediate code |
| loadCtrl | input | 1 | Load the mask from the control word's low bits |
| immCode | input | 7 | Immediate count code |
| ctrlWord | input | 16 | Control word; only bits [6:0] are used |
| maskOut | output | 64 | Registered mask |

## Verification
The codes tried are 0, 1, 63, 64, 65, 100 and 127. Code 0 and code 64 are the two extremes, all ones and all zeros. Codes 63 and 65 sit on either side of the point where the zero run moves from the top end to the bottom end. Code 1 and code 127 each clear a single bit, one at each end. Control-word loads carry junk in bits [15:7] to show those bits are ignored. Same-edge strobes and idle edges with changing inputs separate the priority rule from the hold rule.

// File: rtl/postMaskPkg.sv
package postMaskPkg;
  parameter int MASK_W = 64;
  parameter int CODE_W = $clog2(MASK_W) + 1;
  parameter int CTRL_W = 16;

  typedef struct packed {
    logic load;
    logic useCtrl;
  } maskCtlT;
endpackage

// File: rtl/postMaskCtl.sv
module postMaskCtl
  import postMaskPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadImm,
  input  logic    loadCtrl,
  output maskCtlT ctl
);
  always_comb begin
    ctl.load    = loadImm | loadCtrl;
    ctl.useCtrl = loadCtrl & ~loadImm;
  end

  // the control source is never chosen while the immediate strobe is up
  assert_imm_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadImm |-> !ctl.useCtrl);
  assert_ctrl_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadCtrl && !loadImm) |-> (ctl.useCtrl && ctl.load));
endmodule

// File: rtl/postMaskDp.sv
module postMaskDp
  import postMaskPkg::*;
#(
  parameter int MW = MASK_W,
  parameter int CW = CODE_W,
  parameter int TW = CTRL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  maskCtlT       ctl,
  input  logic [CW-1:0] immCode,
  input  logic [TW-1:0] ctrlWord,
  output logic [MW-1:0] maskOut
);
  localparam int WRAP = 2 * MW;

  logic [CW-1:0] codeSel;
  logic          wrapMode;
  logic [CW:0]   runLen;
  logic [MW-1:0] maskNext;

  assign codeSel  = ctl.useCtrl ? ctrlWord[CW-1:0] : immCode;
  assign wrapMode = codeSel[CW-1];
  // zero-run length: code itself for the top end, WRAP - code for the bottom end
  assign runLen   = wrapMode ? (CW+1)'(WRAP - int'(codeSel)) : {1'b0, codeSel};

  for (genvar b = 0; b < MW; b++) begin : gBit
    always_comb begin
      if (wrapMode) maskNext[b] = (b >= int'(runLen));
      else          maskNext[b] = (b + int'(runLen) < MW);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         maskOut <= '1;
    else if (ctl.load) maskOut <= maskNext;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(maskOut));
  assert_top_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !wrapMode) |=> ($countones(maskOut) == MW - int'($past(codeSel))));
  assert_top_msb_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !wrapMode && codeSel != '0) |=> !maskOut[MW-1]);
  assert_bottom_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && wrapMode) |=> ($countones(maskOut) == int'($past(codeSel)) - MW));
  assert_bottom_lsb_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && wrapMode) |=> !maskOut[0]);
endmodule

// File: rtl/postMaskGen.sv
module postMaskGen
  import postMaskPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadImm,
  input  logic              loadCtrl,
  input  logic [CODE_W-1:0] immCode,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [MASK_W-1:0] maskOut
);
  maskCtlT ctl;

  postMaskCtl uCtl (
    .clk(clk), .rstN(rstN), .loadImm(loadImm), .loadCtrl(loadCtrl), .ctl(ctl)
  );

  postMaskDp #(.MW(MASK_W), .CW(CODE_W), .TW(CTRL_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .immCode(immCode),
    .ctrlWord(ctrlWord), .maskOut(maskOut)
  );
endmodule

// File: tb/sim_postMaskGen.sv
module sim_postMaskGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadImm = 1'b0;
  logic        loadCtrl = 1'b0;
  logic [6:0]  immCode = '0;
  logic [15:0] ctrlWord = '0;
  logic [63:0] maskOut;
  int checks = 0;
  int errors = 0;

  postMaskGen u0 (.clk(clk), .rstN(rstN), .loadImm(loadImm), .loadCtrl(loadCtrl),
                  .immCode(immCode), .ctrlWord(ctrlWord), .maskOut(maskOut));

  always #5 clk = ~clk;

  function automatic logic [63:0] expMask(input int n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      if (n < 64) m[i] = (i < 64 - n);
      else        m[i] = (i >= 128 - n);
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (maskOut !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, maskOut, exp);
    end
  endtask

  // drive at negedge, strobe through one posedge, check at next negedge
  task automatic pulse(input logic li, input logic lc, input logic [6:0] ic,
                       input logic [15:0] cw);
    @(negedge clk);
    loadImm = li; loadCtrl = lc; immCode = ic; ctrlWord = cw;
    @(negedge clk);
    loadImm = 1'b0; loadCtrl = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset", 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testImm();
    int codes[7] = '{0, 1, 63, 64, 65, 100, 127};
    foreach (codes[k]) begin
      pulse(1'b1, 1'b0, 7'(codes[k]), 16'h0);
      if (codes[k] == 0)      check("R2 R5 code0", 64'hFFFF_FFFF_FFFF_FFFF);
      else if (codes[k] < 64) check("R3 R5 top run", expMask(codes[k]));
      else                    check("R4 R5 bottom run", expMask(codes[k]));
    end
    pulse(1'b1, 1'b0, 7'd64, 16'h0);
    check("R4 code64 zero", 64'h0);
    pulse(1'b1, 1'b0, 7'd127, 16'h0);
    check("R4 code127", 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic testCtrl();
    pulse(1'b0, 1'b1, 7'd0, 16'hAB85);   // low 7 bits = 5
    check("R6 ctrl code5", expMask(5));
    pulse(1'b0, 1'b1, 7'd0, 16'hFFC6);   // low 7 bits = 70
    check("R6 ctrl code70", expMask(70));
    pulse(1'b0, 1'b1, 7'd9, 16'hFF80);   // low 7 bits = 0
    check("R6 ctrl upper ignored", 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testPriority();
    pulse(1'b1, 1'b1, 7'd10, 16'h0050);
    check("R7 imm wins", expMask(10));
  endtask

  task automatic testHold();
    pulse(1'b1, 1'b0, 7'd20, 16'h0);
    @(negedge clk); immCode = 7'd99; ctrlWord = 16'h0033;
    @(negedge clk); immCode = 7'd1;
    @(negedge clk);
    check("R8 hold", expMask(20));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImm();
    testCtrl();
    testPriority();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule